// File: doc/BRIEF.md
# Byte Shift, Rotate and Digit-Rotate Unit

This unit sits in the datapath of an 8-bit processor. It takes one operand byte and a carry bit and applies one of seven single-bit shift or rotate operations: circular left and right, left and right through carry, arithmetic left and right, and logical right. It returns the shifted byte, the bit that was shifted out and three condition flags. A shift is accepted on a `start` pulse. Its result, carry and flags are registered, and `done` rises on the following cycle.

The unit also performs two digit rotations. Each one moves three 4-bit nibbles among the low nibble of the accumulator and the two nibbles of a byte in memory. A digit rotation reads the memory byte with one handshake, writes the modified byte back with a second handshake, and then reports the new accumulator value on `result`. While a digit rotation is in progress, `busy` is high and any new `start` is dropped.

Top module: `shrot_unit`

## Requirements
- R1: Opcode 0 (rotate left circular) gives result = {d[6:0], d[7]} and carry_out = d[7].
- R2: Opcode 1 (rotate right circular) gives result = {d[0], d[7:1]} and carry_out = d[0].
- R3: Opcode 2 (rotate left through carry) gives {d[6:0], carry_in} with carry_out = d[7]. Opcode 3 (rotate right through carry) gives {carry_in, d[7:1]} with carry_out = d[0].
- R4: Opcode 4 (arithmetic shift left) gives {d[6:0], 0} with carry_out = d[7].
- R5: Opcode 5 (arithmetic shift right) gives {d[7], d[7:1]} with carry_out = d[0].
- R6: Opcode 6 (logical shift right) gives {0, d[7:1]} with carry_out = d[0].
- R7: When `done` is high, flag_zero = (result == 0), flag_sign = result[7], and flag_parity = 1 exactly when result has an even number of one bits.
- R8: A shift opcode (0 to 6) accepted while idle produces `done` high on the next cycle, carrying that operation's result. `busy` stays low throughout.
- R9: Opcode 8 (digit rotate left) writes back memory byte {m[3:0], a[3:0]} and gives a new accumulator {a[7:4], m[7:4]}.
- R10: Opcode 9 (digit rotate right) writes back memory byte {a[3:0], m[7:4]} and gives a new accumulator {a[7:4], m[3:0]}.
- R11: A digit rotation first holds `mem_rd` until `mem_ack`, then holds `mem_wr` with stable `mem_wdata` until `mem_ack`. The two requests are never high together. `done` follows the write acknowledge, and carry_out equals the carry_in sampled at start.
- R12: A `start` that arrives while `busy` is high is ignored: no extra `done` and no change to the digit rotation in progress.
- R13: Opcodes 7 and 10 to 15 are ignored: no `done`, no `busy`, and result is unchanged.
- R14: After reset, done, busy, mem_rd, mem_wr, result, carry_out and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation |
| op | input | 4 | Operation code |
| operand | input | 8 | Byte to shift or rotate |
| carry_in | input | 1 | Incoming carry flag |
| acc_in | input | 8 | Accumulator value for digit rotations |
| mem_rdata | input | 8 | Memory read data, valid with mem_ack during a read |
| mem_ack | input | 1 | Memory acknowledge for the pending request |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wdata | output | 8 | Write-back byte |
| busy | output | 1 | Digit rotation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Shifted byte or new accumulator |
| carry_out | output | 1 | Resulting carry flag |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Result bit 7 |
| flag_parity | output | 1 | Result has even parity |

## Verification
The one overlap this block allows is a shift request arriving while a digit rotation is waiting on its read or write acknowledge. The bench injects a shift `start` in the middle of selected digit rotations, with memory latency varied from zero to two cycles. It then checks that the digit rotation still finishes with the correct write-back byte and accumulator, and that no extra `done` pulse follows. The shifts are swept over every operand value and both carry values. The digit rotations are swept over all memory bytes against a spread of accumulator values.

// File: rtl/shrot_pkg.sv
// Package: opcode encoding and classification helpers shared by the unit.
// Assumes a 4-bit operation field; codes not listed are reserved.
package shrot_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ROL_CIRC  = 4'd0,
        OP_ROR_CIRC  = 4'd1,
        OP_ROL_CARRY = 4'd2,
        OP_ROR_CARRY = 4'd3,
        OP_SHL_ARITH = 4'd4,
        OP_SHR_ARITH = 4'd5,
        OP_SHR_LOGIC = 4'd6,
        OP_DIGIT_L   = 4'd8,
        OP_DIGIT_R   = 4'd9
    } shrot_op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_READ = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

    // Classify a raw code as one of the single-cycle shift operations
    function automatic logic op_is_shift(input logic [OP_W-1:0] code);
        return (code <= 4'd6);
    endfunction

    // Classify a raw code as one of the two digit rotations
    function automatic logic op_is_digit(input logic [OP_W-1:0] code);
        return (code == 4'd8) || (code == 4'd9);
    endfunction

endpackage

// File: rtl/shrot_shifter.sv
// Module: combinational one-bit shifter/rotator.
// Assumes W >= 2; reserved codes pass data through with carry_in as carry.
module shrot_shifter #(
    parameter int W = 8
) (
    input  logic [shrot_pkg::OP_W-1:0] op,
    input  logic [W-1:0]               din,
    input  logic                       cin,
    output logic [W-1:0]               dout,
    output logic                       cout
);
    import shrot_pkg::*;

    localparam int MSB = W - 1;

    // Select the shifted value and the bit that falls out
    always_comb begin
        dout = din;
        cout = cin;
        case (op)
            OP_ROL_CIRC:  begin dout = {din[MSB-1:0], din[MSB]}; cout = din[MSB]; end
            OP_ROR_CIRC:  begin dout = {din[0], din[MSB:1]};     cout = din[0];   end
            OP_ROL_CARRY: begin dout = {din[MSB-1:0], cin};      cout = din[MSB]; end
            OP_ROR_CARRY: begin dout = {cin, din[MSB:1]};        cout = din[0];   end
            OP_SHL_ARITH: begin dout = {din[MSB-1:0], 1'b0};     cout = din[MSB]; end
            OP_SHR_ARITH: begin dout = {din[MSB], din[MSB:1]};   cout = din[0];   end
            OP_SHR_LOGIC: begin dout = {1'b0, din[MSB:1]};       cout = din[0];   end
            default:      begin dout = din;                      cout = cin;      end
        endcase
    end

    // R6
    always_comb begin
        if (op == OP_SHR_LOGIC) begin
            srl_top_zero_chk: assert (dout[MSB] == 1'b0);
        end
    end

endmodule

// File: rtl/shrot_digit_mix.sv
// Module: combinational nibble exchange for the two digit rotations.
// Assumes W is even; only the low nibble of the accumulator takes part.
module shrot_digit_mix #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mem,
    input  logic         dir_right,
    output logic [W-1:0] acc_new,
    output logic [W-1:0] mem_new
);
    localparam int NIB = W / 2;

    logic [NIB-1:0] acc_hi, acc_lo, mem_hi, mem_lo;

    // Split both bytes into nibbles
    always_comb begin
        acc_hi = acc[W-1:NIB];
        acc_lo = acc[NIB-1:0];
        mem_hi = mem[W-1:NIB];
        mem_lo = mem[NIB-1:0];
    end

    // Rotate the three nibbles one way or the other
    always_comb begin
        if (dir_right) begin
            acc_new = {acc_hi, mem_lo};
            mem_new = {acc_lo, mem_hi};
        end else begin
            acc_new = {acc_hi, mem_hi};
            mem_new = {mem_lo, acc_lo};
        end
    end

endmodule

// File: rtl/shrot_flags.sv
// Module: combinational zero, sign and even-parity flags of a byte.
// Assumes parity flag convention: 1 means an even count of ones.
module shrot_flags #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    output logic         zero,
    output logic         sign,
    output logic         parity
);
    // Derive the three condition flags
    always_comb begin
        zero   = (value == '0);
        sign   = value[W-1];
        parity = ~(^value);
    end

endmodule

// File: rtl/shrot_digit_seq.sv
// Module: read-then-write memory sequencer for digit rotations.
// Assumes mem_ack is only meaningful while a request is held.
module shrot_digit_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic mem_ack,
    output logic mem_rd,
    output logic mem_wr,
    output logic capture,
    output logic finish,
    output logic busy
);
    import shrot_pkg::*;

    seq_state_e state_q;

    // Advance through idle, read and write phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            case (state_q)
                SEQ_IDLE:  if (launch)  state_q <= SEQ_READ;
                SEQ_READ:  if (mem_ack) state_q <= SEQ_WRITE;
                SEQ_WRITE: if (mem_ack) state_q <= SEQ_IDLE;
                default:                state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Decode requests and phase events
    always_comb begin
        mem_rd  = (state_q == SEQ_READ);
        mem_wr  = (state_q == SEQ_WRITE);
        capture = mem_rd && mem_ack;
        finish  = mem_wr && mem_ack;
        busy    = (state_q != SEQ_IDLE);
    end

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> $past(mem_rd) && $past(mem_ack));

endmodule

// File: rtl/shrot_unit.sv
// Module: top of the shift/rotate/digit-rotate unit.
// Assumes one operation at a time; start is dropped while busy.
module shrot_unit #(
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [shrot_pkg::OP_W-1:0] op,
    input  logic [W-1:0]               operand,
    input  logic                       carry_in,
    input  logic [W-1:0]               acc_in,
    input  logic [W-1:0]               mem_rdata,
    input  logic                       mem_ack,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic [W-1:0]               mem_wdata,
    output logic                       busy,
    output logic                       done,
    output logic [W-1:0]               result,
    output logic                       carry_out,
    output logic                       flag_zero,
    output logic                       flag_sign,
    output logic                       flag_parity
);
    import shrot_pkg::*;

    logic         accept_shift, accept_digit;
    logic         capture, finish;
    logic [W-1:0] shift_val;
    logic         shift_cout;
    logic [W-1:0] acc_lat_q, acc_new_q, mem_new_q;
    logic         dir_right_q, cin_lat_q;
    logic [W-1:0] mix_acc, mix_mem;
    logic [W-1:0] flag_src;
    logic         fz, fs, fp;

    // Qualify a new request against the current phase
    always_comb begin
        accept_shift = start && !busy && op_is_shift(op);
        accept_digit = start && !busy && op_is_digit(op);
    end

    shrot_shifter #(.W(W)) u_shifter (
        .op   (op),
        .din  (operand),
        .cin  (carry_in),
        .dout (shift_val),
        .cout (shift_cout)
    );

    shrot_digit_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (accept_digit),
        .mem_ack (mem_ack),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .capture (capture),
        .finish  (finish),
        .busy    (busy)
    );

    shrot_digit_mix #(.W(W)) u_mix (
        .acc       (acc_lat_q),
        .mem       (mem_rdata),
        .dir_right (dir_right_q),
        .acc_new   (mix_acc),
        .mem_new   (mix_mem)
    );

    // Pick the byte whose flags will be registered this cycle
    always_comb begin
        flag_src = finish ? acc_new_q : shift_val;
    end

    shrot_flags #(.W(W)) u_flags (
        .value  (flag_src),
        .zero   (fz),
        .sign   (fs),
        .parity (fp)
    );

    // Latch digit-rotation context at launch and the mixed bytes at read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_lat_q   <= '0;
            dir_right_q <= 1'b0;
            cin_lat_q   <= 1'b0;
            acc_new_q   <= '0;
            mem_new_q   <= '0;
        end else begin
            if (accept_digit) begin
                acc_lat_q   <= acc_in;
                dir_right_q <= (op == OP_DIGIT_R);
                cin_lat_q   <= carry_in;
            end
            if (capture) begin
                acc_new_q <= mix_acc;
                mem_new_q <= mix_mem;
            end
        end
    end

    // Register the visible result, carry, flags and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result      <= '0;
            carry_out   <= 1'b0;
            flag_zero   <= 1'b0;
            flag_sign   <= 1'b0;
            flag_parity <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= accept_shift || finish;
            if (finish) begin
                result    <= acc_new_q;
                carry_out <= cin_lat_q;
            end else if (accept_shift) begin
                result    <= shift_val;
                carry_out <= shift_cout;
            end
            if (finish || accept_shift) begin
                flag_zero   <= fz;
                flag_sign   <= fs;
                flag_parity <= fp;
            end
        end
    end

    // Drive the write-back byte from the held mixed value
    always_comb begin
        mem_wdata = mem_new_q;
    end

    // R8
    shift_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && op_is_shift(op) |=> done && !busy);

    // R13
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !op_is_shift(op) && !op_is_digit(op) |=> !done && !busy && $stable(result));

    // R12
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy && !mem_wr |=> !done);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flag_zero == (result == '0));

    // R11
    wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_ack |=> $stable(mem_wdata));

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] operand = 8'd0;
    logic       carry_in = 1'b0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] mem_rdata = 8'd0;
    logic       mem_ack = 1'b0;
    logic       mem_rd, mem_wr, busy, done, carry_out;
    logic       flag_zero, flag_sign, flag_parity;
    logic [7:0] mem_wdata, result;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] mem_byte = 8'd0;
    int         lat = 0;
    int         waited = 0;
    logic       rd_seen = 1'b0;
    logic       wr_seen = 1'b0;
    logic       order_bad = 1'b0;
    logic [7:0] wr_data = 8'd0;

    always #5 clk = ~clk;

    shrot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .operand(operand),
        .carry_in(carry_in), .acc_in(acc_in), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .busy(busy),
        .done(done), .result(result), .carry_out(carry_out), .flag_zero(flag_zero),
        .flag_sign(flag_sign), .flag_parity(flag_parity)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory responder: acknowledges each request after lat idle cycles
    initial begin
        forever begin
            @(negedge clk);
            if ((mem_rd || mem_wr) && !mem_ack && waited >= lat) begin
                mem_ack = 1'b1;
                if (mem_wr) begin
                    wr_seen = 1'b1;
                    wr_data = mem_wdata;
                    if (!rd_seen) order_bad = 1'b1;
                end else begin
                    rd_seen = 1'b1;
                    mem_rdata = mem_byte;
                end
                waited = 0;
            end else begin
                mem_ack = 1'b0;
                if (mem_rd || mem_wr) waited++;
            end
        end
    end

    function automatic int exp_shift(input int code, input int v, input int c, output int co);
        int r;
        case (code)
            0: begin r = ((v << 1) | (v >> 7)) & 255; co = v >> 7; end
            1: begin r = (v >> 1) | ((v & 1) << 7);   co = v & 1;  end
            2: begin r = ((v << 1) | c) & 255;        co = v >> 7; end
            3: begin r = (v >> 1) | (c << 7);         co = v & 1;  end
            4: begin r = (v << 1) & 255;              co = v >> 7; end
            5: begin r = (v >> 1) | (v & 128);        co = v & 1;  end
            default: begin r = v >> 1;                co = v & 1;  end
        endcase
        return r;
    endfunction

    task automatic check_flags(input int r, input string req);
        chk(flag_zero == (r == 0), req, flag_zero, (r == 0));
        chk(flag_sign == r[7], req, flag_sign, r[7]);
        chk(flag_parity == ($countones(r[7:0]) % 2 == 0), req, flag_parity,
            ($countones(r[7:0]) % 2 == 0));
    endtask

    task automatic do_shift(input int code, input int v, input int c);
        int co, r;
        string tag;
        r = exp_shift(code, v, c, co);
        case (code)
            0: tag = "R1"; 1: tag = "R2"; 2, 3: tag = "R3";
            4: tag = "R4"; 5: tag = "R5"; default: tag = "R6";
        endcase
        start = 1'b1; op = code[3:0]; operand = v[7:0]; carry_in = c[0];
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R8", {done, busy}, 2);
        chk(result == r[7:0], tag, result, r);
        chk(carry_out == co[0], tag, carry_out, co);
        check_flags(r, "R7");
        @(negedge clk);
    endtask

    task automatic do_digit(input int code, input int a, input int m, input int c,
                            input int l, input bit inject);
        int ea, em, n;
        bit seen;
        string tag;
        tag = (code == 8) ? "R9" : "R10";
        if (code == 8) begin
            ea = (a & 240) | (m >> 4);
            em = ((m & 15) << 4) | (a & 15);
        end else begin
            ea = (a & 240) | (m & 15);
            em = ((a & 15) << 4) | (m >> 4);
        end
        mem_byte = m[7:0]; lat = l; waited = 0;
        rd_seen = 1'b0; wr_seen = 1'b0; order_bad = 1'b0;
        start = 1'b1; op = code[3:0]; acc_in = a[7:0]; carry_in = c[0];
        operand = 8'hA5;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (done) begin seen = 1'b1; break; end
            if (inject && i == 1) begin
                start = 1'b1; op = 4'd0; acc_in = ~a[7:0]; carry_in = ~c[0];
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(seen, "R11", seen, 1);
        chk(wr_seen && !order_bad, "R11", {wr_seen, order_bad}, 2);
        chk(wr_data == em[7:0], tag, wr_data, em);
        chk(result == ea[7:0], tag, result, ea);
        chk(carry_out == c[0], "R11", carry_out, c);
        check_flags(ea, "R7");
        @(negedge clk);
        n = done;
        chk(n == 0 && !busy, "R12", {done, busy}, 0);
    endtask

    // Watchdog
    initial begin
        #1500000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] keep;
        @(negedge clk);
        @(negedge clk);
        // R14 reset state
        chk(!done && !busy && !mem_rd && !mem_wr, "R14", {done, busy, mem_rd, mem_wr}, 0);
        chk(result == 0 && !carry_out, "R14", {result, carry_out}, 0);
        chk(!flag_zero && !flag_sign && !flag_parity, "R14",
            {flag_zero, flag_sign, flag_parity}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int code = 0; code < 7; code++)
            for (int v = 0; v < 256; v++)
                for (int c = 0; c < 2; c++)
                    do_shift(code, v, c);

        // R13 reserved codes
        do_shift(0, 8'h81, 0);
        keep = result;
        for (int code = 7; code < 16; code++) begin
            if (code == 8 || code == 9) continue;
            start = 1'b1; op = code[3:0]; operand = 8'h3C;
            @(negedge clk);
            start = 1'b0;
            chk(!done && !busy && result == keep, "R13", {done, busy, result}, {2'b00, keep});
            @(negedge clk);
        end

        for (int code = 8; code < 10; code++)
            for (int a = 0; a < 256; a += 17)
                for (int m = 0; m < 256; m++)
                    do_digit(code, a ^ 8'h50, m, m & 1, (a + m) % 3, (m % 7) == 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule